// File: doc/BRIEF.md
# Maximum-Deficit Queue Refill Selector

This block steers the head cache of a hybrid packet buffer, in which a large, slow DRAM holds the bodies of many cell FIFOs and a small SRAM holds the head cells of each one. The arbiter may take a cell from any of the queues in any slot, and that cell must come straight out of SRAM. The block keeps a count of cells per queue in SRAM and a signed deficit per queue. The deficit is the number of cells taken from the queue minus the cells put back into it by refills.

Once every B cell slots the block picks the queue with the largest positive deficit and issues one refill order for B cells over the single DRAM address bus. It then waits for the refill-done strobe before it orders another refill. The SRAM cache is sized to NQ·B·(2 + ln NQ) cells, with ln approximated from log2. With that size the greedy largest-deficit choice needs no lookahead, and every request is served with zero added latency. If a request arrives for a queue that holds no cells, the block raises a sticky underflow flag.

Top module: `mdq_refill_sel`

## Requirements
- R1: While reset is low at a clock edge, every queue's occupancy becomes INIT_FILL, every deficit becomes 0, and refill_valid and underflow become 0.
- R2: A request for a queue whose occupancy is above zero lowers that queue's occupancy by 1 at the same clock edge. Every other queue's occupancy stays unchanged unless that queue receives a refill.
- R3: A request for a queue whose occupancy is zero leaves the occupancy at zero and sets underflow at that edge. Underflow then stays at 1 until reset.
- R4: Slots are counted from the release of reset. A refill can only be ordered at every B-th rising edge (edges B, 2B, …). refill_valid is high for exactly the one cycle that follows such an edge.
- R5: A refill order carries, in refill_qid, the index of the queue with the largest deficit as it stood before the deciding edge. Among equal largest deficits, the lowest index wins. A request arriving at the deciding edge itself is not counted in that decision.
- R6: If no queue has a deficit above zero at a deciding edge, no refill is ordered.
- R7: From the refill order until refill_done has been seen, no further refill is ordered, even at a deciding edge.
- R8: refill_done, while an order is outstanding, adds B to the ordered queue's occupancy (capped at the cache size) and takes B off its deficit. refill_done with no order outstanding changes nothing. Deficits saturate at the limits of their signed range and never wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Cell-slot clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Arbiter takes one cell this slot |
| req_qid | input | QW | Queue the cell is taken from |
| refill_done | input | 1 | Outstanding B-cell refill has landed in SRAM |
| refill_valid | output | 1 | One-cycle refill order |
| refill_qid | output | QW | Queue to refill; meaningful while refill_valid is high |
| underflow | output | 1 | Sticky: a request found its queue empty |
| occ_flat | output | NQ*OW | Per-queue SRAM occupancy; queue i in bits [i*OW +: OW] |

## Verification
The deficit counters are only visible through the choice the block makes, so a wrong deficit shows up as a wrong refill_qid. That error appears at the first deciding edge after the fault, which is no more than B cycles later. A wrong occupancy shows on occ_flat in the cycle after the edge that caused it. It also leads to a false or missing underflow when the queue runs dry. A lost outstanding-order flag shows as an order that is missing or one too many at the next deciding edge.

// File: rtl/mdq_pkg.sv
// Shared sizing helpers for the maximum-deficit refill selector.
// Assumes: queue count and refill size are small positive integers.
package mdq_pkg;

    // Cache size in cells: nq*b*(2 + ln nq), ln taken as 0.693*log2, rounded up.
    function automatic int cache_cells(input int nq, input int b);
        return nq * b * 2 + (nq * b * $clog2(nq) * 693 + 999) / 1000;
    endfunction

endpackage

// File: rtl/mdq_slot_timer.sv
// Cell-slot counter that marks every B-th slot as a refill decision slot.
// Assumes: B >= 2; the count restarts at zero on synchronous reset.
module mdq_slot_timer #(
    parameter int B = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int SW = $clog2(B);

    logic [SW-1:0] slot;

    // Decision slot is the last slot of each B-slot window.
    assign tick = (slot == SW'(B - 1));

    // Advance the slot count, wrapping after B slots.
    always_ff @(posedge clk) begin
        if (!rst_n)    slot <= '0;
        else if (tick) slot <= '0;
        else           slot <= slot + SW'(1);
    end
endmodule

// File: rtl/mdq_queue_ctr.sv
// Per-queue SRAM occupancy and signed deficit bookkeeping.
// Assumes: req_hit and fill_hit may both be high in one slot; occupancy
// never goes below zero and is capped at CAP; the deficit saturates.
module mdq_queue_ctr #(
    parameter int INIT = 4,
    parameter int CAP  = 55,
    parameter int B    = 4,
    parameter int OW   = 6,
    parameter int DW   = 7
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_hit,
    input  logic                 fill_hit,
    output logic [OW-1:0]        occ,
    output logic signed [DW-1:0] deficit,
    output logic                 empty
);
    localparam int DMAX = (2 ** (DW - 1)) - 1;
    localparam int DMIN = -(2 ** (DW - 1));

    logic [OW-1:0]        occ_nx;
    logic signed [DW-1:0] def_nx;

    assign empty = (occ == '0);

    // Next occupancy: one cell out per served request, B in per refill, capped.
    always_comb begin
        int o;
        o = int'(occ);
        if (req_hit && !empty) o = o - 1;
        if (fill_hit)          o = o + B;
        if (o > CAP)           o = CAP;
        occ_nx = OW'(o);
    end

    // Next deficit: +1 per request, -B per refill, saturating both ways.
    always_comb begin
        int d;
        d = int'(deficit);
        if (req_hit)  d = d + 1;
        if (fill_hit) d = d - B;
        if (d > DMAX) d = DMAX;
        if (d < DMIN) d = DMIN;
        def_nx = DW'(d);
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ     <= OW'(INIT);
            deficit <= '0;
        end else begin
            occ     <= occ_nx;
            deficit <= def_nx;
        end
    end
endmodule

// File: rtl/mdq_max_pick.sv
// Finds the queue with the largest signed deficit; ties go to the lowest index.
// Assumes: NQ >= 2; deficits are packed queue 0 in the low bits.
module mdq_max_pick #(
    parameter int NQ = 4,
    parameter int DW = 7,
    parameter int QW = 2
) (
    input  logic [NQ*DW-1:0] def_flat,
    output logic [QW-1:0]    best_q,
    output logic             best_pos
);
    // Linear scan with a strict compare so that the earliest maximum is kept.
    always_comb begin
        logic signed [DW-1:0] best_v;
        logic signed [DW-1:0] cur;
        int                   best_i;
        best_v = signed'(def_flat[DW-1:0]);
        best_i = 0;
        for (int i = 1; i < NQ; i++) begin
            cur = signed'(def_flat[i*DW +: DW]);
            if (cur > best_v) begin
                best_v = cur;
                best_i = i;
            end
        end
        best_q   = QW'(best_i);
        best_pos = (best_v > 0);
    end
endmodule

// File: rtl/mdq_refill_sel.sv
// Zero-latency head-cache controller: serves every request from SRAM at once,
// tracks per-queue deficits, and every B slots orders a B-cell DRAM refill for
// the queue with the largest positive deficit. At most one order is outstanding.
// Assumes: NQ >= 2, B >= 2, refill_done pulses once per order.
module mdq_refill_sel #(
    parameter int NQ        = 4,
    parameter int B         = 4,
    parameter int INIT_FILL = B,
    localparam int QW  = $clog2(NQ),
    localparam int CAP = mdq_pkg::cache_cells(NQ, B),
    localparam int OW  = $clog2(CAP + 1),
    localparam int DW  = OW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [QW-1:0]    req_qid,
    input  logic             refill_done,
    output logic             refill_valid,
    output logic [QW-1:0]    refill_qid,
    output logic             underflow,
    output logic [NQ*OW-1:0] occ_flat
);
    logic              tick;
    logic              pend;
    logic              req_empty;
    logic [NQ-1:0]     req_hit;
    logic [NQ-1:0]     fill_hit;
    logic [NQ-1:0]     empty;
    logic [NQ*DW-1:0]  def_flat;
    logic [QW-1:0]     best_q;
    logic              best_pos;

    mdq_slot_timer #(.B(B)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_q
        logic [OW-1:0]        occ_q;
        logic signed [DW-1:0] def_q;

        assign req_hit[q]  = req_valid && (req_qid == QW'(q));
        assign fill_hit[q] = refill_done && pend && (refill_qid == QW'(q));

        mdq_queue_ctr #(
            .INIT (INIT_FILL),
            .CAP  (CAP),
            .B    (B),
            .OW   (OW),
            .DW   (DW)
        ) u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .req_hit  (req_hit[q]),
            .fill_hit (fill_hit[q]),
            .occ      (occ_q),
            .deficit  (def_q),
            .empty    (empty[q])
        );

        assign occ_flat[q*OW +: OW] = occ_q;
        assign def_flat[q*DW +: DW] = def_q;
    end

    mdq_max_pick #(.NQ(NQ), .DW(DW), .QW(QW)) u_pick (
        .def_flat (def_flat),
        .best_q   (best_q),
        .best_pos (best_pos)
    );

    assign req_empty = |(req_hit & empty);

    // Sticky underflow: set when a request finds its queue empty.
    always_ff @(posedge clk) begin
        if (!rst_n)         underflow <= 1'b0;
        else if (req_empty) underflow <= 1'b1;
    end

    // Refill order: one per decision slot when idle and some deficit is positive.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            refill_valid <= 1'b0;
            refill_qid   <= '0;
            pend         <= 1'b0;
        end else if (tick && !pend && best_pos) begin
            refill_valid <= 1'b1;
            refill_qid   <= best_q;
            pend         <= 1'b1;
        end else begin
            refill_valid <= 1'b0;
            if (refill_done) pend <= 1'b0;
        end
    end
endmodule

// File: rtl/mdq_refill_sel_chk.sv
// Property checker for the refill selector, attached by bind below.
// Keeps its own slot count and outstanding-order flag to judge the outputs.
module mdq_refill_sel_chk #(
    parameter int NQ  = 4,
    parameter int B   = 4,
    parameter int QW  = 2,
    parameter int OW  = 6,
    parameter int CAP = 55
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [QW-1:0]    req_qid,
    input logic             refill_done,
    input logic             refill_valid,
    input logic [QW-1:0]    refill_qid,
    input logic             underflow,
    input logic [NQ*OW-1:0] occ_flat
);
    localparam int CW = $clog2(B);

    logic [CW-1:0] c_slot;
    logic          c_pend;

    // Independent slot counter, wrapping after B edges.
    always_ff @(posedge clk) begin
        if (!rst_n)                       c_slot <= '0;
        else if (c_slot == CW'(B - 1))    c_slot <= '0;
        else                              c_slot <= c_slot + CW'(1);
    end

    // Independent outstanding-order tracker.
    always_ff @(posedge clk) begin
        if (!rst_n)            c_pend <= 1'b0;
        else if (refill_done)  c_pend <= 1'b0;
        else if (refill_valid) c_pend <= 1'b1;
    end

    AST_REFILL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        refill_valid |=> !refill_valid); // R4
    AST_REFILL_CADENCE: assert property (@(posedge clk) disable iff (!rst_n)
        refill_valid |-> (c_slot == '0)); // R4
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        c_pend |-> !refill_valid); // R7
    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow); // R3
    AST_UNDERFLOW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(underflow) |-> $past(req_valid)); // R3

    for (genvar q = 0; q < NQ; q++) begin : g_chk
        AST_OCC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(req_valid) && !$past(refill_done))
            |-> $stable(occ_flat[q*OW +: OW])); // R2
        AST_OCC_CAP: assert property (@(posedge clk) disable iff (!rst_n)
            int'(occ_flat[q*OW +: OW]) <= CAP); // R8
    end
endmodule

bind mdq_refill_sel mdq_refill_sel_chk #(
    .NQ (NQ), .B (B), .QW (QW), .OW (OW), .CAP (CAP)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_qid      (req_qid),
    .refill_done  (refill_done),
    .refill_valid (refill_valid),
    .refill_qid   (refill_qid),
    .underflow    (underflow),
    .occ_flat     (occ_flat)
);

// File: tb/mdq_refill_sel_bench.sv
`timescale 1ns/1ps
// Bench for the refill selector at default parameters (4 queues, B=4, 6-bit occupancy).
module mdq_refill_sel_bench;
    localparam int NQ = 4;
    localparam int QW = 2;
    localparam int OW = 6;
    localparam int NV = 28;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid;
    logic [QW-1:0]    req_qid;
    logic             refill_done;
    logic             refill_valid;
    logic [QW-1:0]    refill_qid;
    logic             underflow;
    logic [NQ*OW-1:0] occ_flat;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mdq_refill_sel u_mdq_refill_sel (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_qid      (req_qid),
        .refill_done  (refill_done),
        .refill_valid (refill_valid),
        .refill_qid   (refill_qid),
        .underflow    (underflow),
        .occ_flat     (occ_flat)
    );

    // Row layout: req, qid, done | exp refill_valid, exp refill_qid, exp underflow,
    // exp occupancy q0..q3. Row k is the slot before rising edge k after reset.
    localparam logic [31:0] VEC [NV] = '{
        {1'b1,2'd1,1'b0, 1'b0,2'd0,1'b0, 6'd4,6'd3,6'd4,6'd4}, // 1  R2
        {1'b1,2'd2,1'b0, 1'b0,2'd0,1'b0, 6'd4,6'd3,6'd3,6'd4}, // 2  R2
        {1'b1,2'd2,1'b0, 1'b0,2'd0,1'b0, 6'd4,6'd3,6'd2,6'd4}, // 3  R2
        {1'b1,2'd1,1'b0, 1'b1,2'd2,1'b0, 6'd4,6'd2,6'd2,6'd4}, // 4  R4 R5 (edge-4 request not counted)
        {1'b0,2'd0,1'b1, 1'b0,2'd0,1'b0, 6'd4,6'd2,6'd6,6'd4}, // 5  R8
        {1'b1,2'd1,1'b0, 1'b0,2'd0,1'b0, 6'd4,6'd1,6'd6,6'd4}, // 6
        {1'b1,2'd3,1'b0, 1'b0,2'd0,1'b0, 6'd4,6'd1,6'd6,6'd3}, // 7
        {1'b1,2'd3,1'b0, 1'b1,2'd1,1'b0, 6'd4,6'd1,6'd6,6'd2}, // 8  R5
        {1'b1,2'd1,1'b0, 1'b0,2'd0,1'b0, 6'd4,6'd0,6'd6,6'd2}, // 9
        {1'b1,2'd1,1'b0, 1'b0,2'd0,1'b1, 6'd4,6'd0,6'd6,6'd2}, // 10 R3
        {1'b0,2'd0,1'b0, 1'b0,2'd0,1'b1, 6'd4,6'd0,6'd6,6'd2}, // 11 R3 sticky
        {1'b0,2'd0,1'b0, 1'b0,2'd0,1'b1, 6'd4,6'd0,6'd6,6'd2}, // 12 R7 order outstanding
        {1'b0,2'd0,1'b1, 1'b0,2'd0,1'b1, 6'd4,6'd4,6'd6,6'd2}, // 13 R8
        {1'b0,2'd0,1'b0, 1'b0,2'd0,1'b1, 6'd4,6'd4,6'd6,6'd2}, // 14
        {1'b0,2'd0,1'b0, 1'b0,2'd0,1'b1, 6'd4,6'd4,6'd6,6'd2}, // 15
        {1'b0,2'd0,1'b0, 1'b1,2'd3,1'b1, 6'd4,6'd4,6'd6,6'd2}, // 16 R5
        {1'b0,2'd0,1'b1, 1'b0,2'd0,1'b1, 6'd4,6'd4,6'd6,6'd6}, // 17
        {1'b1,2'd0,1'b0, 1'b0,2'd0,1'b1, 6'd3,6'd4,6'd6,6'd6}, // 18
        {1'b0,2'd0,1'b0, 1'b0,2'd0,1'b1, 6'd3,6'd4,6'd6,6'd6}, // 19
        {1'b0,2'd0,1'b0, 1'b1,2'd0,1'b1, 6'd3,6'd4,6'd6,6'd6}, // 20 R5 tie -> lowest
        {1'b0,2'd0,1'b1, 1'b0,2'd0,1'b1, 6'd7,6'd4,6'd6,6'd6}, // 21
        {1'b1,2'd1,1'b0, 1'b0,2'd0,1'b1, 6'd7,6'd3,6'd6,6'd6}, // 22
        {1'b0,2'd0,1'b1, 1'b0,2'd0,1'b1, 6'd7,6'd3,6'd6,6'd6}, // 23 R8 stray done
        {1'b0,2'd0,1'b0, 1'b1,2'd1,1'b1, 6'd7,6'd3,6'd6,6'd6}, // 24
        {1'b0,2'd0,1'b1, 1'b0,2'd0,1'b1, 6'd7,6'd7,6'd6,6'd6}, // 25
        {1'b0,2'd0,1'b0, 1'b0,2'd0,1'b1, 6'd7,6'd7,6'd6,6'd6}, // 26
        {1'b0,2'd0,1'b0, 1'b0,2'd0,1'b1, 6'd7,6'd7,6'd6,6'd6}, // 27
        {1'b0,2'd0,1'b0, 1'b0,2'd0,1'b1, 6'd7,6'd7,6'd6,6'd6}  // 28 R6 all deficits <= 0
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int occ_of(input int q);
        return int'(occ_flat[q*OW +: OW]);
    endfunction

    task automatic drive(input logic rv, input int q, input logic dn);
        req_valid   = rv;
        req_qid     = QW'(q);
        refill_done = dn;
    endtask

    task automatic chk_occ(input string tag, input int o0, input int o1, input int o2, input int o3);
        chk(tag, occ_of(0), o0);
        chk(tag, occ_of(1), o1);
        chk(tag, occ_of(2), o2);
        chk(tag, occ_of(3), o3);
    endtask

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 refill_valid", int'(refill_valid), 0);
        chk("R1 underflow", int'(underflow), 0);
        chk_occ("R1 occupancy", 4, 4, 4, 4);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k][31], int'(VEC[k][30:29]), VEC[k][28]);
            @(negedge clk);
            chk("R4 R6 R7 refill_valid", int'(refill_valid), int'(VEC[k][27]));
            if (VEC[k][27]) chk("R5 refill_qid", int'(refill_qid), int'(VEC[k][26:25]));
            chk("R3 underflow", int'(underflow), int'(VEC[k][24]));
            chk_occ("R2 R8 occupancy", int'(VEC[k][23:18]), int'(VEC[k][17:12]),
                    int'(VEC[k][11:6]), int'(VEC[k][5:0]));
        end

        // R1: reset in mid-run clears the sticky flag and restores the fill.
        drive(1'b0, 0, 1'b0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 underflow cleared", int'(underflow), 0);
        chk_occ("R1 occupancy restored", 4, 4, 4, 4);
        rst_n = 1'b1;

        // Drain queue 0: edges 1..4 take its four cells.
        for (int k = 0; k < 4; k++) begin
            drive(1'b1, 0, 1'b0);
            @(negedge clk);
        end
        chk("R2 drained", occ_of(0), 0);
        chk("R4 refill_valid at edge 4", int'(refill_valid), 1);
        chk("R5 refill_qid drained queue", int'(refill_qid), 0);
        chk("R3 no underflow yet", int'(underflow), 0);
        // Edge 5: request on the empty queue.
        drive(1'b1, 0, 1'b0);
        @(negedge clk);
        chk("R3 underflow on empty", int'(underflow), 1);
        chk("R3 occupancy held at zero", occ_of(0), 0);
        chk("R4 pulse one cycle", int'(refill_valid), 0);
        // Edge 6: refill lands.
        drive(1'b0, 0, 1'b1);
        @(negedge clk);
        chk("R8 refill adds B", occ_of(0), 4);
        // Edge 7: stray done must not add cells.
        drive(1'b0, 0, 1'b1);
        @(negedge clk);
        chk("R8 stray done ignored", occ_of(0), 4);
        drive(1'b0, 0, 1'b0);
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule